// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces four pulse-width modulated outputs from a single free-running timebase. A 31-bit counter advances once per clock while counting is enabled. The counter value is shifted right by a programmable 4-bit amount, and the lower 16 bits of the result form the scaled count. Each channel compares the scaled count with its own 16-bit threshold. A full period therefore lasts 2^(16+shift) clocks, and the shift is the only way to set the period.

Outputs are active-low. A channel drives its pin low while counting is running and the scaled count is below that channel's threshold. At all other times it drives the pin high. A threshold of zero keeps the channel permanently high. Even the largest threshold, 0xFFFF, leaves one scaled count per period high, so the block never produces a constant low level.

Software sets up the block through a single-cycle register port with byte addresses. The port holds the setup word, two read-only views of the timebase and the four thresholds. A threshold written while the block runs is used from the next clock, not from the next period boundary, so one period may combine the old and new thresholds.

The timebase control is a two-state machine. In **HOLD** the counter keeps its value and every output stays high. In **COUNT** the counter advances by one each clock. The machine takes the *start* transition from HOLD to COUNT when the enable bit reads 1. It takes the *stop* transition from COUNT to HOLD when the enable bit reads 0. In every other case it stays in its current state. The state register samples the enable bit, so a change of the enable bit reaches the counter and the outputs one clock after the write.

Top module: `scaled_pwm`

## Requirements
- R1: Reset sets the setup word, the counter and all four thresholds to zero and drives all four outputs high.
- R2: Address 0x00 holds the setup word. The shift amount is in bits [3:0] and the enable bit is bit 12. Every other bit of the setup word reads zero. Threshold i is at address 0x20+4*i and reads back as the low 16 bits of the value written.
- R3: While enabled, the counter, readable at 0x08, increases by exactly one each clock and wraps at 2^31.
- R4: With the enable bit clear, the counter keeps its value and all outputs stay high, whatever the thresholds hold.
- R5: Address 0x10 reads the scaled count, which equals counter bits [shift+15:shift].
- R6: While enabled, output i is low exactly when the scaled count is below threshold i. Over 65536 consecutive clocks with shift 0, the output is low for exactly threshold-many clocks.
- R7: A threshold of zero keeps its output high at all times.
- R8: With threshold 0xFFFF the output is high while the scaled count equals 0xFFFF, so no period is entirely low.
- R9: A threshold write changes the output from the next clock onward, without waiting for the end of the period.
- R10: Reads of unmapped addresses return zero. Writes to 0x08, 0x10 or unmapped addresses change no register and do not change the counter.
- R11: Setup bit 9 (counter restart on match) has no effect. It reads back as zero and the counter keeps advancing past the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_n | output | 4 | Active-low channel outputs |

## Verification
The assertions assume that reset is applied before any edge is checked. They also assume the register port is the only way the setup word and the thresholds change. Under these conditions the counter step, the hold behaviour and the output relations follow from the internal timebase alone. The stimulus changes inputs only on falling clock edges and writes one register per cycle. It leaves time after every change of the enable bit so the state machine can settle, and it reads the timebase only in cycles where its value can be predicted from an earlier read.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PWM_NUM_CH  = 4;
    localparam int PWM_CMP_W   = 16;
    localparam int PWM_SHIFT_W = 4;
    localparam int PWM_ADDR_W  = 8;
    localparam int PWM_DATA_W  = 32;

    localparam int OFS_SETUP   = 'h00;
    localparam int OFS_COUNT   = 'h08;
    localparam int OFS_SCALED  = 'h10;
    localparam int OFS_THR0    = 'h20;
    localparam int THR_STRIDE  = 4;

    localparam int SETUP_EN_BIT = 12;

    typedef enum logic {
        TB_HOLD  = 1'b0,
        TB_COUNT = 1'b1
    } tb_state_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CMP_W   = PWM_CMP_W,
    parameter int SHIFT_W = PWM_SHIFT_W,
    localparam int CNT_W  = CMP_W + (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [SHIFT_W-1:0] shift,
    output logic               run_active,
    output logic [CNT_W-1:0]   count,
    output logic [CMP_W-1:0]   scaled
);
    tb_state_t state_q, state_d;
    logic [CNT_W-1:0] shifted;
    logic             unused_shifted;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_HOLD;
        else        state_q <= state_d;
    end

    // transitions: start (HOLD->COUNT), stop (COUNT->HOLD)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_HOLD:  if (cfg_en)  state_d = TB_COUNT;
            TB_COUNT: if (!cfg_en) state_d = TB_HOLD;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run_active = 1'b0;
        unique case (state_q)
            TB_HOLD:  run_active = 1'b0;
            TB_COUNT: run_active = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count <= '0;
        else if (run_active) count <= count + 1'b1;
    end

    assign shifted        = count >> shift;
    assign scaled         = shifted[CMP_W-1:0];
    assign unused_shifted = ^shifted[CNT_W-1:CMP_W];
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH  = PWM_NUM_CH,
    parameter int CMP_W   = PWM_CMP_W,
    parameter int SHIFT_W = PWM_SHIFT_W,
    parameter int ADDR_W  = PWM_ADDR_W,
    parameter int DATA_W  = PWM_DATA_W,
    localparam int CNT_W  = CMP_W + (1 << SHIFT_W) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [CNT_W-1:0]        count,
    input  logic [CMP_W-1:0]        scaled,
    output logic                    cfg_en,
    output logic [SHIFT_W-1:0]      shift,
    output logic [NUM_CH*CMP_W-1:0] thr_flat
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en <= 1'b0;
            shift  <= '0;
        end else if (wr && addr == ADDR_W'(OFS_SETUP)) begin
            cfg_en <= wdata[SETUP_EN_BIT];
            shift  <= wdata[SHIFT_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_thr
        localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(OFS_THR0 + THR_STRIDE * i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                thr_flat[i*CMP_W +: CMP_W] <= '0;
            else if (wr && addr == THR_ADDR)
                thr_flat[i*CMP_W +: CMP_W] <= wdata[CMP_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_SETUP)) begin
            rdata[SHIFT_W-1:0]  = shift;
            rdata[SETUP_EN_BIT] = cfg_en;
        end else if (addr == ADDR_W'(OFS_COUNT)) begin
            rdata[CNT_W-1:0] = count;
        end else if (addr == ADDR_W'(OFS_SCALED)) begin
            rdata[CMP_W-1:0] = scaled;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(OFS_THR0 + THR_STRIDE * i))
                    rdata[CMP_W-1:0] = thr_flat[i*CMP_W +: CMP_W];
            end
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CMP_W = PWM_CMP_W
) (
    input  logic             run_active,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] thr,
    output logic             out_n
);
    logic in_active;
    assign in_active = run_active && (scaled < thr);
    assign out_n     = ~in_active;
endmodule

// File: rtl/scaled_pwm.sv
module scaled_pwm
    import pwm_pkg::*;
#(
    parameter int NUM_CH  = PWM_NUM_CH,
    parameter int CMP_W   = PWM_CMP_W,
    parameter int SHIFT_W = PWM_SHIFT_W,
    parameter int ADDR_W  = PWM_ADDR_W,
    parameter int DATA_W  = PWM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_n
);
    localparam int CNT_W = CMP_W + (1 << SHIFT_W) - 1;

    logic                    cfg_en;
    logic [SHIFT_W-1:0]      shift;
    logic                    run_active;
    logic [CNT_W-1:0]        count_q;
    logic [CMP_W-1:0]        scaled;
    logic [NUM_CH*CMP_W-1:0] thr_flat;

    pwm_regfile #(
        .NUM_CH(NUM_CH), .CMP_W(CMP_W), .SHIFT_W(SHIFT_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .count(count_q),
        .scaled(scaled), .cfg_en(cfg_en), .shift(shift), .thr_flat(thr_flat)
    );

    pwm_timebase #(.CMP_W(CMP_W), .SHIFT_W(SHIFT_W)) i_tbase (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .shift(shift),
        .run_active(run_active), .count(count_q), .scaled(scaled)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel #(.CMP_W(CMP_W)) i_ch (
            .run_active(run_active),
            .scaled(scaled),
            .thr(thr_flat[i*CMP_W +: CMP_W]),
            .out_n(pwm_n[i])
        );
    end
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16,
    parameter int CNT_W  = 31
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run_active,
    input logic [CNT_W-1:0]        count,
    input logic [CMP_W-1:0]        scaled,
    input logic [NUM_CH*CMP_W-1:0] thr_flat,
    input logic [NUM_CH-1:0]       pwm_n
);
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        run_active |=> count == $past(count) + 1'b1);

    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_active |=> $stable(count));

    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run_active |-> pwm_n == '1);

    a_r8_top_count_high: assert property (@(posedge clk) disable iff (!rst_n)
        scaled == '1 |-> pwm_n == '1);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r7_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
            thr_flat[i*CMP_W +: CMP_W] == '0 |-> pwm_n[i]);

        a_r6_active_low: assert property (@(posedge clk) disable iff (!rst_n)
            (run_active && scaled < thr_flat[i*CMP_W +: CMP_W]) |-> !pwm_n[i]);
    end
endmodule

bind scaled_pwm pwm_checker #(
    .NUM_CH(NUM_CH), .CMP_W(CMP_W), .CNT_W(CNT_W)
) i_pwm_checker (
    .clk(clk), .rst_n(rst_n), .run_active(run_active), .count(count_q),
    .scaled(scaled), .thr_flat(thr_flat), .pwm_n(pwm_n)
);

// File: tb/test_scaled_pwm.sv
`timescale 1ns/1ps
module test_scaled_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_n;

    int checks = 0;
    int failures = 0;
    logic [15:0] thr_m [4];

    always #5 clk = ~clk;

    scaled_pwm i_scaled_pwm (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_n(pwm_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(8'h00, v); check(v == 0, "R1 setup", v, 0);
        bus_read(8'h08, v); check(v == 0, "R1 count", v, 0);
        bus_read(8'h10, v); check(v == 0, "R1 scaled", v, 0);
        for (int i = 0; i < 4; i++) begin
            bus_read(8'h20 + 8'(4*i), v); check(v == 0, "R1 threshold", v, 0);
        end
        check(pwm_n == 4'hF, "R1 outputs", {28'd0, pwm_n}, 32'hF);
        wait_cycles(5);
        bus_read(8'h08, v); check(v == 0, "R4 held after reset", v, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        bus_write(8'h00, 32'hFFFF_FDFF);
        bus_read(8'h00, v); check(v == 32'h0000_100F, "R2 setup readback", v, 32'h0000_100F);
        bus_write(8'h00, 32'h0);
        for (int i = 0; i < 4; i++) begin
            bus_write(8'h20 + 8'(4*i), 32'hABC0_0000 | 32'(16'h1111 * (i + 1)));
        end
        for (int i = 0; i < 4; i++) begin
            bus_read(8'h20 + 8'(4*i), v);
            check(v == 32'(16'h1111 * (i + 1)), "R2 threshold readback", v, 32'(16'h1111 * (i + 1)));
        end
        wait_cycles(3);
        bus_read(8'h08, v);
        begin
            logic [31:0] c0;
            c0 = v;
            bus_write(8'h08, 32'h1234_5678);
            bus_write(8'h10, 32'h0000_FFFF);
            bus_write(8'h04, 32'hFFFF_FFFF);
            bus_write(8'h30, 32'hFFFF_FFFF);
            bus_read(8'h08, v); check(v == c0, "R10 counter untouched", v, c0);
        end
        bus_read(8'h00, v); check(v == 0, "R10 setup untouched", v, 0);
        bus_read(8'h24, v); check(v == 32'h2222, "R10 threshold untouched", v, 32'h2222);
        bus_read(8'h04, v); check(v == 0, "R10 unmapped 0x04", v, 0);
        bus_read(8'h14, v); check(v == 0, "R10 unmapped 0x14", v, 0);
        bus_read(8'h30, v); check(v == 0, "R10 unmapped 0x30", v, 0);
        bus_read(8'hFC, v); check(v == 0, "R10 unmapped 0xFC", v, 0);
    endtask

    task automatic t_period();
        logic [31:0] a, b;
        int low [4];
        thr_m[0] = 16'h0000; thr_m[1] = 16'h0001; thr_m[2] = 16'h8000; thr_m[3] = 16'hFFFF;
        for (int i = 0; i < 4; i++) bus_write(8'h20 + 8'(4*i), {16'h0, thr_m[i]});
        bus_write(8'h00, 32'h0000_1000);
        wait_cycles(2);
        bus_read(8'h08, a);
        wait_cycles(100);
        bus_read(8'h08, b);
        check(b == a + 100, "R3 step per clock", b, a + 100);
        for (int i = 0; i < 4; i++) low[i] = 0;
        for (int n = 0; n < 65536; n++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (!pwm_n[i]) low[i]++;
        end
        check(low[0] == 0, "R7 zero threshold never low", low[0], 0);
        check(low[1] == 1, "R6 threshold 1 duty", low[1], 1);
        check(low[2] == 32768, "R6 half duty", low[2], 32768);
        check(low[3] == 65535, "R8 top threshold leaves one high", low[3], 65535);
    endtask

    task automatic t_scale();
        logic [31:0] c, s, exp;
        int bad;
        int ks [3] = '{0, 3, 15};
        for (int j = 0; j < 3; j++) begin
            bus_write(8'h00, 32'h0000_1000 | 32'(ks[j]));
            bus_read(8'h08, c);
            @(negedge clk);
            bus_read(8'h10, s);
            exp = ((c + 1) >> ks[j]) & 32'hFFFF;
            check(s == exp, "R5 scaled count", s, exp);
        end
        bus_write(8'h00, 32'h0000_1003);
        bad = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            bus_read(8'h10, s);
            for (int i = 0; i < 4; i++)
                if (pwm_n[i] != !(s[15:0] < thr_m[i])) bad++;
        end
        check(bad == 0, "R6 output vs scaled count", bad, 0);
    endtask

    task automatic t_live_update();
        logic [31:0] s;
        bus_write(8'h00, 32'h0000_1000);
        bus_write(8'h20, 32'h0);
        bus_read(8'h10, s);
        while (s[15:0] >= 16'hF000) begin
            @(negedge clk);
            bus_read(8'h10, s);
        end
        check(pwm_n[0] == 1'b1, "R9 before update", {31'd0, pwm_n[0]}, 1);
        bus_write(8'h20, {16'h0, s[15:0] + 16'd2000});
        check(pwm_n[0] == 1'b0, "R9 update takes effect next clock", {31'd0, pwm_n[0]}, 0);
        thr_m[0] = s[15:0] + 16'd2000;
    endtask

    task automatic t_zero_cmp_and_stop();
        logic [31:0] a, b, v;
        bus_write(8'h00, 32'h0000_1200);
        bus_read(8'h00, v); check(v == 32'h0000_1000, "R11 bit 9 reads zero", v, 32'h0000_1000);
        wait_cycles(1);
        bus_read(8'h08, a);
        wait_cycles(70000);
        bus_read(8'h08, b);
        check(b == a + 70000, "R11 counter runs past period", b, a + 70000);
        bus_write(8'h00, 32'h0);
        wait_cycles(3);
        bus_read(8'h08, a);
        wait_cycles(20);
        bus_read(8'h08, b);
        check(b == a, "R4 counter holds when disabled", b, a);
        check(pwm_n == 4'hF, "R4 outputs high when disabled", {28'd0, pwm_n}, 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_period();
        t_scale();
        t_live_update();
        t_zero_cmp_and_stop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_990_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule